// File: doc/BRIEF.md
# Four-Channel Edge Timestamper

This block timestamps transitions on four asynchronous logic inputs. Each input is brought into the clock domain by a two-stage synchroniser. It then passes through a debounce stage, which accepts a new level only after the synchronised signal has held that level for a set number of consecutive cycles. A change in the accepted level is an edge. For every edge whose type is enabled for its channel, the block forms one 64-bit message. The message holds a free-running cycle count, the channel index and the polarity of the edge.

Messages collect in an on-chip queue, and a DMA engine drains that queue through a valid/ready stream. The queue absorbs the engine's start-up delay. If the queue is full, messages are discarded. The stream later carries a single marker word that shows where an unknown number of messages went missing. Edges seen on several channels in the same cycle are serialised into the queue one per cycle. They are written in a fixed order and all carry the same timestamp.

Top module: `timetag_unit`

## Requirements
- R1: A synchronous reset clears the cycle counter, the queue and the loss indication. Each debounce stage loads the level its input has during reset, so input levels held through reset never produce a message, and after reset `msg_valid` stays low until an edge is accepted.
- R2: The cycle counter starts at 0 after reset and increments by one every clock. A level change on an input that holds for at least FILT_LEN cycles is stamped with the counter value of the clock edge FILT_LEN+2 edges after the edge that first samples the new level. If the input is changed just after a clock edge, the stamp is the counter value at that moment plus 6 (FILT_LEN=4).
- R3: A level change on an input that lasts fewer than FILT_LEN (4) consecutive cycles produces no message. A change that lasts exactly FILT_LEN cycles produces one message.
- R4: An event message has bits [63:60]=0, bits [59:58]=channel index, bit 57=1 for a rising edge and 0 for a falling edge, bits [56:48]=0 and bits [47:0]=timestamp.
- R5: `en_rise[c]` and `en_fall[c]` independently allow rising and falling edges of channel c to produce messages. An edge whose enable is low produces nothing.
- R6: Edges accepted in the same cycle on several channels are queued in ascending channel order and share one timestamp. Message timestamps never decrease along the stream.
- R7: Messages leave in the order they were queued. While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and `msg_data` stays unchanged.
- R8: A message that finds the queue full is discarded and a loss indication is set. At the next free slot exactly one marker word is queued, with bits [63:60]=1 and all other bits 0. It goes in before any later event, and the indication then clears.
- R9: The queue stores 2**FIFO_AW messages. With the stream stalled, exactly that many messages are retained and the rest are discarded under R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | N_CH | Asynchronous logic inputs to be timestamped |
| en_rise | input | N_CH | Per-channel rising-edge enable |
| en_fall | input | N_CH | Per-channel falling-edge enable |
| msg_ready | input | 1 | Consumer accepts the current word |
| msg_valid | output | 1 | A queued word is presented |
| msg_data | output | 64 | Queued message word |

## Verification
The embedded assertions check several properties on every cycle. The counter must step by exactly one. An accepted level must have been seen on the synchronised input on the preceding cycles. The write side must never push into a full queue, and a pending loss marker must win the write slot. Written timestamps must be non-decreasing, and a stalled output word must stay stable. Some behaviours can only be shown by the bench's scenarios against its queue-based reference model. These are the exact stamp values and the channel ordering of simultaneous edges. They also include suppression by the enables and rejection of short pulses. The last are how many words survive a full queue and where the single marker appears in the stream.

// File: rtl/tt_pkg.sv
package tt_pkg;

   localparam int MSG_W   = 64;
   localparam int STAMP_W = 48;

   localparam logic [3:0] KIND_EVENT = 4'h0;
   localparam logic [3:0] KIND_LOST  = 4'h1;

   // Event word: kind | channel | polarity | zero pad | stamp
   function automatic logic [MSG_W-1:0] pack_event(input logic [1:0]         ch,
                                                   input logic               is_rise,
                                                   input logic [STAMP_W-1:0] stamp);
      return {KIND_EVENT, ch, is_rise, 9'd0, stamp};
   endfunction

   function automatic logic [MSG_W-1:0] pack_lost();
      return {KIND_LOST, 60'd0};
   endfunction

endpackage

// File: rtl/tt_chan_cond.sv
module tt_chan_cond #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise_o,
   output logic fall_o
);

   localparam int CW = $clog2(FILT_LEN);
   localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

   logic          meta_q;
   logic          sync_q;
   logic          lvl_q;
   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         meta_q <= din;
         sync_q <= din;
         lvl_q  <= din;
         run_q  <= '0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else begin
         meta_q <= din;
         sync_q <= meta_q;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
         if (sync_q != lvl_q) begin
            if (run_q == LAST) begin
               lvl_q  <= sync_q;
               run_q  <= '0;
               rise_o <= sync_q;
               fall_o <= ~sync_q;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   // An accepted level must already have been present on the synchroniser
   AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (lvl_q != $past(lvl_q)) |-> ($past(sync_q) == lvl_q && $past(sync_q, 2) == lvl_q)); // R3

endmodule

// File: rtl/tt_event_merge.sv
module tt_event_merge
   import tt_pkg::*;
#(
   parameter int N_CH = 4,
   parameter int TS_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_CH-1:0]  rise_i,
   input  logic [N_CH-1:0]  fall_i,
   input  logic [N_CH-1:0]  en_rise_i,
   input  logic [N_CH-1:0]  en_fall_i,
   input  logic [TS_W-1:0]  ts_i,
   input  logic             fifo_full_i,
   output logic             wr_en_o,
   output logic [MSG_W-1:0] wr_data_o
);

   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

   logic [N_CH-1:0]            pend_q;
   logic [N_CH-1:0]            pol_q;
   logic [N_CH-1:0][TS_W-1:0]  stamp_q;
   logic                       lost_q;

   logic [N_CH-1:0] hit;
   logic [N_CH-1:0] drain;
   logic [N_CH-1:0] collide;

   for (genvar c = 0; c < N_CH; c++) begin : g_hit
      assign hit[c] = (rise_i[c] & en_rise_i[c]) | (fall_i[c] & en_fall_i[c]);
   end

   // Oldest pending slot; equal stamps resolve to the lower channel
   logic            sel_vld;
   logic [CH_W-1:0] sel_ch;
   logic [TS_W-1:0] sel_ts;

   always_comb begin
      sel_vld = 1'b0;
      sel_ch  = '0;
      sel_ts  = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (pend_q[c] && (!sel_vld || stamp_q[c] < sel_ts)) begin
            sel_vld = 1'b1;
            sel_ch  = CH_W'(c);
            sel_ts  = stamp_q[c];
         end
      end
   end

   logic send_lost;
   logic take;
   logic drop_full;

   always_comb begin
      send_lost = lost_q && !fifo_full_i;
      take      = sel_vld && !send_lost;
      drop_full = take && fifo_full_i;
      wr_en_o   = send_lost || (take && !fifo_full_i);
      wr_data_o = send_lost ? pack_lost()
                            : pack_event(2'(sel_ch), pol_q[sel_ch], STAMP_W'(sel_ts));
      for (int c = 0; c < N_CH; c++) begin
         drain[c]   = take && (sel_ch == CH_W'(c));
         collide[c] = hit[c] && pend_q[c] && !drain[c];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= '0;
         pol_q   <= '0;
         stamp_q <= '0;
         lost_q  <= 1'b0;
      end else begin
         for (int c = 0; c < N_CH; c++) begin
            if (hit[c] && (!pend_q[c] || drain[c])) begin
               pend_q[c]  <= 1'b1;
               pol_q[c]   <= rise_i[c];
               stamp_q[c] <= ts_i;
            end else if (drain[c]) begin
               pend_q[c] <= 1'b0;
            end
         end
         if (drop_full || (|collide)) begin
            lost_q <= 1'b1;
         end else if (send_lost) begin
            lost_q <= 1'b0;
         end
      end
   end

   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
      wr_en_o |-> !fifo_full_i); // R8

   AST_MARK_FIRST: assert property (@(posedge clk) disable iff (rst)
      (lost_q && !fifo_full_i) |-> (wr_en_o && wr_data_o[63:60] == KIND_LOST)); // R8

   AST_STAMP_ORDER: assert property (@(posedge clk) disable iff (rst)
      (wr_en_o && wr_data_o[63:60] == KIND_EVENT
       && $past(wr_en_o && wr_data_o[63:60] == KIND_EVENT))
      |-> (wr_data_o[47:0] >= $past(wr_data_o[47:0]))); // R6

endmodule

// File: rtl/tt_msg_fifo.sv
module tt_msg_fifo #(
   parameter int W  = 64,
   parameter int AW = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   output logic         full_o,
   output logic         rd_valid_o,
   input  logic         rd_ready_i,
   output logic [W-1:0] rd_data_o
);

   localparam int          DEPTH = 1 << AW;
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q;
   logic [AW-1:0] rp_q;
   logic [AW:0]   cnt_q;

   logic push;
   logic pop;

   assign full_o     = (cnt_q == FULL_CNT);
   assign rd_valid_o = (cnt_q != '0);
   assign rd_data_o  = mem[rp_q];
   assign push       = wr_en_i && !full_o;
   assign pop        = rd_valid_o && rd_ready_i;

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp_q] <= wr_data_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
      (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R7

endmodule

// File: rtl/timetag_unit.sv
module timetag_unit
   import tt_pkg::*;
#(
   parameter int N_CH     = 4,
   parameter int FILT_LEN = 4,
   parameter int TS_W     = 48,
   parameter int FIFO_AW  = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_CH-1:0]  sig_in,
   input  logic [N_CH-1:0]  en_rise,
   input  logic [N_CH-1:0]  en_fall,
   input  logic             msg_ready,
   output logic             msg_valid,
   output logic [MSG_W-1:0] msg_data
);

   if (N_CH < 1 || N_CH > 4) begin : g_bad_nch
      $error("timetag_unit: N_CH must lie in 1..4 to fit the channel field");
   end
   if (FILT_LEN < 2) begin : g_bad_filt
      $error("timetag_unit: FILT_LEN must be at least 2");
   end
   if (TS_W < 1 || TS_W > STAMP_W) begin : g_bad_ts
      $error("timetag_unit: TS_W must lie in 1..48");
   end
   if (FIFO_AW < 1 || FIFO_AW > 16) begin : g_bad_aw
      $error("timetag_unit: FIFO_AW must lie in 1..16");
   end

   logic [TS_W-1:0] ts_q;

   always_ff @(posedge clk) begin
      if (rst) ts_q <= '0;
      else     ts_q <= ts_q + 1'b1;
   end

   logic [N_CH-1:0] rise;
   logic [N_CH-1:0] fall;

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      tt_chan_cond #(.FILT_LEN(FILT_LEN)) u_cond (
         .clk    (clk),
         .rst    (rst),
         .din    (sig_in[c]),
         .rise_o (rise[c]),
         .fall_o (fall[c])
      );
   end

   logic             wr_en;
   logic [MSG_W-1:0] wr_data;
   logic             fifo_full;

   tt_event_merge #(.N_CH(N_CH), .TS_W(TS_W)) u_merge (
      .clk         (clk),
      .rst         (rst),
      .rise_i      (rise),
      .fall_i      (fall),
      .en_rise_i   (en_rise),
      .en_fall_i   (en_fall),
      .ts_i        (ts_q),
      .fifo_full_i (fifo_full),
      .wr_en_o     (wr_en),
      .wr_data_o   (wr_data)
   );

   tt_msg_fifo #(.W(MSG_W), .AW(FIFO_AW)) u_fifo (
      .clk        (clk),
      .rst        (rst),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .full_o     (fifo_full),
      .rd_valid_o (msg_valid),
      .rd_ready_i (msg_ready),
      .rd_data_o  (msg_data)
   );

   AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (ts_q == $past(ts_q) + 1'b1)); // R2

endmodule

// File: tb/tb_timetag_unit.sv
`timescale 1ns/1ps
module tb_timetag_unit;

   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int LAT   = 6;   // 2 sync stages + FILT_LEN of 4

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  din = 4'b1010;
   logic [3:0]  en_r = 4'hF;
   logic [3:0]  en_f = 4'hF;
   logic        rdy = 1'b1;
   logic        mv;
   logic [63:0] md;

   always #2.5 clk = ~clk;

   timetag_unit #(.N_CH(4), .FILT_LEN(4), .TS_W(48), .FIFO_AW(AW)) dut (
      .clk       (clk),
      .rst       (rst),
      .sig_in    (din),
      .en_rise   (en_r),
      .en_fall   (en_f),
      .msg_ready (rdy),
      .msg_valid (mv),
      .msg_data  (md)
   );

   int          n_run  = 0;
   int          n_fail = 0;
   longint      tb_cnt = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];
   string       cur = "R1";
   bit          hold = 1'b0;
   bit          m_lost = 1'b0;
   logic        held = 1'b0;
   logic [63:0] held_data = '0;

   // Reference cycle counter (R2): cleared by reset, +1 per clock
   always @(posedge clk) tb_cnt <= rst ? 64'd0 : tb_cnt + 1;

   // R4 field layout
   function automatic logic [63:0] mk_ev(int ch, bit r, longint ts);
      return {4'h0, 2'(ch), r, 9'd0, 48'(ts)};
   endfunction

   localparam logic [63:0] MARK = {4'h1, 60'd0};   // R8 marker word

   task automatic finish_tb();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push_ev(int ch, bit r);
      if (!(r ? en_r[ch] : en_f[ch])) return;          // R5 suppression
      if (hold && exp_q.size() >= DEPTH) begin         // R9 capacity
         m_lost = 1'b1;
      end else begin
         if (m_lost) begin
            exp_q.push_back(MARK);
            tag_q.push_back("R8");
            m_lost = 1'b0;
         end
         exp_q.push_back(mk_ev(ch, r, tb_cnt + LAT));
         tag_q.push_back(cur);
      end
   endtask

   // Change inputs just after an edge; ascending channel order (R6)
   task automatic drive(logic [3:0] nv);
      @(posedge clk);
      #1;
      for (int c = 0; c < 4; c++)
         if (nv[c] != din[c]) push_ev(c, nv[c]);
      din = nv;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   // Per-clock comparison against the reference queue
   always @(negedge clk) begin : mon
      logic [63:0] e;
      string       t;
      if (!rst) begin
         if (held) begin
            n_run++;
            if (!mv || md !== held_data) begin
               n_fail++;
               $display("FAIL R7 stalled word: got valid=%0b %h expected valid=1 %h",
                        mv, md, held_data);
            end
         end
         held      = mv && !rdy;
         held_data = md;
         if (mv && rdy) begin
            n_run++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL %s unexpected word: got %h expected none", cur, md);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (md !== e) begin
                  n_fail++;
                  $display("FAIL %s stream word: got %h expected %h", t, md, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_tb();
   end

   initial begin
      // R1: inputs sit at 1010 through reset; nothing may come out
      repeat (8) @(posedge clk);
      #1 rst = 1'b0;
      idle(20);
      @(negedge clk);
      chk(mv == 1'b0, "R1", "valid after reset", 64'(mv), 64'd0);

      // R4: single channel rise then fall
      cur = "R4";
      drive(4'b1011);
      idle(12);
      drive(4'b1010);
      idle(12);

      // R2: different channels a few cycles apart, distinct stamps
      cur = "R2";
      drive(4'b0010);
      idle(5);
      drive(4'b0110);
      idle(15);

      // R6: all channels change in one cycle, then two together
      cur = "R6";
      drive(4'b1001);
      idle(15);
      drive(4'b1111);
      idle(15);

      // R5: ch1 rising and ch2 falling disabled
      cur = "R5";
      en_r = 4'b1101;
      en_f = 4'b1011;
      idle(2);
      drive(4'b0000);
      idle(15);
      drive(4'b1111);
      idle(15);
      en_r = 4'hF;
      en_f = 4'hF;
      idle(2);

      // R3: 3-cycle low pulse on ch2 is rejected, 4-cycle pulse is kept
      cur = "R3";
      @(posedge clk);
      #1 din = 4'b1011;
      repeat (3) @(posedge clk);
      #1 din = 4'b1111;
      idle(20);
      @(negedge clk);
      chk(mv == 1'b0 && exp_q.size() == 0, "R3", "short pulse output", 64'(mv), 64'd0);
      drive(4'b1011);
      repeat (3) @(posedge clk);
      drive(4'b1111);
      idle(20);

      // R7: stall, then release with an irregular ready pattern
      cur = "R7";
      rdy = 1'b0;
      drive(4'b0000);
      idle(14);
      for (int i = 0; i < 24; i++) begin
         @(posedge clk);
         #1 rdy = (i % 3 == 0);
      end
      rdy = 1'b1;
      idle(20);
      @(negedge clk);
      chk(exp_q.size() == 0, "R7", "words left after drain", 64'(exp_q.size()), 64'd0);

      // R8/R9: stall long enough to overfill the queue
      cur  = "R8";
      hold = 1'b1;
      rdy  = 1'b0;
      for (int k = 0; k < 5; k++) begin
         drive(~din);
         idle(8);
      end
      idle(20);
      @(negedge clk);
      chk(mv == 1'b1, "R9", "valid with full queue", 64'(mv), 64'd1);
      chk(exp_q.size() == DEPTH, "R9", "model occupancy", 64'(exp_q.size()), 64'(DEPTH));
      @(posedge clk);
      #1;
      hold = 1'b0;
      if (m_lost) begin
         exp_q.push_back(MARK);
         tag_q.push_back("R8");
         m_lost = 1'b0;
      end
      rdy = 1'b1;
      idle(30);
      drive(~din);
      idle(40);

      @(negedge clk);
      chk(exp_q.size() == 0, "R8", "words missing at end", 64'(exp_q.size()), 64'd0);
      chk(mv == 1'b0, "R7", "valid when drained", 64'(mv), 64'd0);
      finish_tb();
   end

endmodule